// File: doc/BRIEF.md
# Shared Multiplexed-Bus Controller for a Flash and PSRAM Pair

This block sits on the host side of a package that holds a NOR flash die and a PSRAM die. Both dies hang off one 16-bit multiplexed address/data bus. The bus upper address lines are separate, and each die has its own chip select. The host issues one request at a time on a valid/ready interface. A request is a read, a write or a wake. A PSRAM read or write can be turned into a configuration-register access.

For each request the controller first runs an address-latch phase and then a data phase. Phase lengths are fixed by parameters and counted in controller clock cycles. The controller generates the select, latch, output-enable, write-enable, byte-enable and configuration-enable strobes. It drives the shared lines only while it owns them. It never selects both dies at once, and it inserts extra idle cycles when traffic moves from one die to the other.

A shadow copy of the PSRAM refresh configuration register lets the controller know when the PSRAM drops into deep power-down. While the PSRAM is powered down, its accesses are absorbed without touching the bus. A wake request holds the PSRAM select low for a parameterised number of cycles to bring it back.

Top module: `muxbus_dual_ctrl`

## Requirements
- R1: During and directly after synchronous reset, all active-low strobes are high: both selects, latch, output enable, write enable and both byte enables. In the same state, `psram_cre` is low, `adq_oe` is low, `dpd_active` is low and `req_ready` is high.
- R2: `flash_ce_n` and `psram_ce_n` are never low in the same cycle.
- R3: The address phase lasts ADDR_CYC cycles. In it, `bus_adv_n` is low, exactly the target select is low, `bus_oe_n` and `bus_we_n` are high, and `adq_oe` is high. `{bus_a_hi, adq_out}` carries `req_addr`.
- R4: A read (`req_op` 0, and also value 3) has a data phase of DATA_CYC cycles. In it, `bus_adv_n` is high, `bus_oe_n` is low, `bus_we_n` is high and `adq_oe` is low. `rd_data` takes `adq_in` as sampled on the last data cycle, and `rd_valid` pulses once per read.
- R5: A write (`req_op` 1) has a data phase of DATA_CYC cycles. In it, `bus_we_n` is low, `bus_oe_n` is high, `adq_oe` is high and `adq_out` equals `req_wdata`.
- R6: For a PSRAM access, `psram_ub_n` is low throughout both phases exactly when `req_be[1]` is set. `psram_lb_n` is low exactly when `req_be[0]` is set. Flash accesses keep both byte enables high.
- R7: A PSRAM access with `req_cfg` set drives `psram_cre` high in both phases. Address bit 19 is 0 to select the refresh configuration register and 1 to select the bus configuration register. Flash accesses keep `psram_cre` low whatever `req_cfg` is.
- R8: Between two consecutive bus accesses to the same die, both selects are high for at least one cycle. When the die changes, both selects are high for at least 1+TURN_CYC cycles.
- R9: The shadow refresh register resets to 0x0010. A completed PSRAM write to the refresh register whose bit 4 is 0 sets `dpd_active` on the same clock edge that the PSRAM select rises. Writes with bit 4 at 1, and writes to the bus configuration register, leave it clear.
- R10: While `dpd_active` is set, a PSRAM read or write is accepted without any strobe activity, and `req_ready` stays high. Such a read returns 0 and such a write changes nothing. Flash accesses run normally in this state.
- R11: A wake (`req_op` 2) issued while `dpd_active` is set holds `psram_ce_n` low for WAKE_CYC cycles, with the latch, output-enable and write-enable strobes high. It then clears `dpd_active` and returns the shadow register to 0x0010. A wake issued while `dpd_active` is clear causes no bus activity.
- R12: `bus_clk` is held low at all times.
- R13: `req_ready` falls on the cycle after a bus access is accepted and rises again on the cycle after its last data-phase cycle (or last wake cycle). While it is high, both selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 0 read, 1 write, 2 wake, 3 read |
| req_psram | input | 1 | Target die: 1 PSRAM, 0 flash |
| req_cfg | input | 1 | PSRAM configuration-register access |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper byte, bit 0 lower byte |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data |
| dpd_active | output | 1 | PSRAM is in deep power-down |
| bus_clk | output | 1 | Bus clock, held low |
| bus_adv_n | output | 1 | Address latch strobe, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| flash_ce_n | output | 1 | Flash select, active low |
| psram_ce_n | output | 1 | PSRAM select, active low |
| psram_cre | output | 1 | PSRAM configuration-register enable |
| psram_ub_n | output | 1 | PSRAM upper byte enable, active low |
| psram_lb_n | output | 1 | PSRAM lower byte enable, active low |
| bus_a_hi | output | ADDR_W-DATA_W | Upper address lines |
| adq_out | output | DATA_W | Value driven onto the shared lines |
| adq_oe | output | 1 | Drive enable for the shared lines |
| adq_in | input | DATA_W | Value seen on the shared lines |

## Verification
The hardest state to reach from the ports is the powered-down PSRAM. The only way in is a complete configuration-register write whose bit 4 is clear, and once there, every PSRAM request is silently absorbed. The stimulus first writes the refresh register with bit 4 set and confirms that nothing changes. It then clears the bit, sends a PSRAM read, a PSRAM write and a flash read while powered down, and wakes the die. Afterwards it reads back both the refresh register and the earlier PSRAM word, which shows that the shadow returned to its default and that the absorbed write had no effect.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_WAKE  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_ADDR,
    ST_DATA,
    ST_WAKE
  } mbc_state_e;

endpackage

// File: rtl/mbc_phase_timer.sv
module mbc_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/mbc_dpd_track.sv
module mbc_dpd_track #(
  parameter int              DATA_W    = 16,
  parameter int              DPD_BIT   = 4,
  parameter logic [DATA_W-1:0] RCR_RESET = 16'h0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rcr_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              psr_end,
  input  logic              wake_end,
  output logic              dpd
);

  logic [DATA_W-1:0] shadow_q;
  logic              dpd_q;
  logic              bit_after;

  assign bit_after = rcr_wr ? wr_data[DPD_BIT] : shadow_q[DPD_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= RCR_RESET;
      dpd_q    <= 1'b0;
    end else if (wake_end) begin
      shadow_q <= RCR_RESET;
      dpd_q    <= 1'b0;
    end else begin
      if (rcr_wr) shadow_q <= wr_data;
      if (psr_end && !bit_after) dpd_q <= 1'b1;
    end
  end

  assign dpd = dpd_q;

  AST_DPD_NEEDS_CLEAR_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(dpd_q) |-> !shadow_q[DPD_BIT]); // R9

endmodule

// File: rtl/mbc_rd_capture.sv
module mbc_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              zero_rd,
  input  logic [DATA_W-1:0] bus_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap | zero_rd;
      if (cap)          rd_data <= bus_in;
      else if (zero_rd) rd_data <= '0;
    end
  end

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !(cap && zero_rd)); // R10

endmodule

// File: rtl/muxbus_dual_ctrl.sv
module muxbus_dual_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int ADDR_CYC    = 2,
  parameter int DATA_CYC    = 3,
  parameter int TURN_CYC    = 2,
  parameter int WAKE_CYC    = 6,
  parameter int CFG_SEL_BIT = 19,
  parameter int DPD_BIT     = 4,
  parameter logic [DATA_W-1:0] RCR_RESET = 16'h0010
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_op,
  input  logic                     req_psram,
  input  logic                     req_cfg,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [1:0]               req_be,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     dpd_active,
  output logic                     bus_clk,
  output logic                     bus_adv_n,
  output logic                     bus_oe_n,
  output logic                     bus_we_n,
  output logic                     flash_ce_n,
  output logic                     psram_ce_n,
  output logic                     psram_cre,
  output logic                     psram_ub_n,
  output logic                     psram_lb_n,
  output logic [ADDR_W-DATA_W-1:0] bus_a_hi,
  output logic [DATA_W-1:0]        adq_out,
  output logic                     adq_oe,
  input  logic [DATA_W-1:0]        adq_in
);

  localparam int HI_W   = ADDR_W - DATA_W;
  localparam int MAX_AD = (ADDR_CYC > DATA_CYC) ? ADDR_CYC : DATA_CYC;
  localparam int MAX_TW = (TURN_CYC > WAKE_CYC) ? TURN_CYC : WAKE_CYC;
  localparam int MAXC   = (MAX_AD > MAX_TW) ? MAX_AD : MAX_TW;
  localparam int CNT_W  = $clog2(MAXC + 1);

  mbc_state_e st_q, st_d;

  logic              ready_q;
  logic [1:0]        op_q;
  logic              psr_q, cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic [1:0]        be_q;
  logic              last_vld_q, last_die_q;

  logic              acc, tdone, dpd;
  logic              req_wake, req_tgt, blocked, wake_noop, need_turn;

  // Fields of the access that the next state belongs to
  logic [1:0]        f_op;
  logic              f_psr, f_cfg, f_wr, act_d;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_wd;
  logic [1:0]        f_be;

  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              data_end, wake_end, psr_end, rcr_wr, cap, zero_rd;

  // Registered bus outputs
  logic              fce_q, pce_q, adv_q, oe_q, we_q, cre_q, ub_q, lb_q, drv_q;
  logic [HI_W-1:0]   ahi_q;
  logic [DATA_W-1:0] dout_q;

  assign acc       = req_valid && ready_q;
  assign req_wake  = (req_op == OP_WAKE);
  assign req_tgt   = req_wake | req_psram;
  assign blocked   = !req_wake && req_psram && dpd;
  assign wake_noop = req_wake && !dpd;
  assign need_turn = last_vld_q && (last_die_q != req_tgt);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (acc && !blocked && !wake_noop)
                 st_d = need_turn ? ST_TURN : (req_wake ? ST_WAKE : ST_ADDR);
      ST_TURN: if (tdone) st_d = (op_q == OP_WAKE) ? ST_WAKE : ST_ADDR;
      ST_ADDR: if (tdone) st_d = ST_DATA;
      ST_DATA: if (tdone) st_d = ST_IDLE;
      ST_WAKE: if (tdone) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    load = (st_d != st_q);
    case (st_d)
      ST_TURN: load_val = CNT_W'(TURN_CYC - 1);
      ST_ADDR: load_val = CNT_W'(ADDR_CYC - 1);
      ST_DATA: load_val = CNT_W'(DATA_CYC - 1);
      ST_WAKE: load_val = CNT_W'(WAKE_CYC - 1);
      default: load_val = '0;
    endcase
  end

  mbc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .done     (tdone)
  );

  assign f_op   = acc ? req_op    : op_q;
  assign f_cfg  = acc ? req_cfg   : cfg_q;
  assign f_addr = acc ? req_addr  : addr_q;
  assign f_wd   = acc ? req_wdata : wd_q;
  assign f_be   = acc ? req_be    : be_q;
  assign f_psr  = (f_op == OP_WAKE) | (acc ? req_psram : psr_q);
  assign f_wr   = (f_op == OP_WRITE);
  assign act_d  = (st_d == ST_ADDR) || (st_d == ST_DATA);

  assign data_end = (st_q == ST_DATA) && tdone;
  assign wake_end = (st_q == ST_WAKE) && tdone;
  assign psr_end  = data_end && psr_q;
  assign rcr_wr   = psr_end && (op_q == OP_WRITE) && cfg_q && !addr_q[CFG_SEL_BIT];
  assign cap      = data_end && (op_q != OP_WRITE);
  assign zero_rd  = acc && blocked && (req_op != OP_WRITE);

  mbc_dpd_track #(
    .DATA_W    (DATA_W),
    .DPD_BIT   (DPD_BIT),
    .RCR_RESET (RCR_RESET)
  ) u_dpd (
    .clk      (clk),
    .rst      (rst),
    .rcr_wr   (rcr_wr),
    .wr_data  (wd_q),
    .psr_end  (psr_end),
    .wake_end (wake_end),
    .dpd      (dpd)
  );

  mbc_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap      (cap),
    .zero_rd  (zero_rd),
    .bus_in   (adq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      ready_q    <= 1'b1;
      op_q       <= OP_READ;
      psr_q      <= 1'b0;
      cfg_q      <= 1'b0;
      addr_q     <= '0;
      wd_q       <= '0;
      be_q       <= '0;
      last_vld_q <= 1'b0;
      last_die_q <= 1'b0;
      fce_q      <= 1'b1;
      pce_q      <= 1'b1;
      adv_q      <= 1'b1;
      oe_q       <= 1'b1;
      we_q       <= 1'b1;
      cre_q      <= 1'b0;
      ub_q       <= 1'b1;
      lb_q       <= 1'b1;
      drv_q      <= 1'b0;
      ahi_q      <= '0;
      dout_q     <= '0;
    end else begin
      st_q    <= st_d;
      ready_q <= (st_d == ST_IDLE);
      if (acc) begin
        op_q   <= req_op;
        psr_q  <= req_psram;
        cfg_q  <= req_cfg;
        addr_q <= req_addr;
        wd_q   <= req_wdata;
        be_q   <= req_be;
      end
      if ((st_d == ST_ADDR && st_q != ST_ADDR) || (st_d == ST_WAKE && st_q != ST_WAKE)) begin
        last_vld_q <= 1'b1;
        last_die_q <= f_psr;
      end
      fce_q  <= !(act_d && !f_psr);
      pce_q  <= !((act_d && f_psr) || (st_d == ST_WAKE));
      adv_q  <= (st_d != ST_ADDR);
      oe_q   <= !((st_d == ST_DATA) && !f_wr);
      we_q   <= !((st_d == ST_DATA) && f_wr);
      drv_q  <= (st_d == ST_ADDR) || ((st_d == ST_DATA) && f_wr);
      dout_q <= (st_d == ST_ADDR) ? f_addr[DATA_W-1:0] :
                (((st_d == ST_DATA) && f_wr) ? f_wd : '0);
      ahi_q  <= act_d ? f_addr[ADDR_W-1:DATA_W] : '0;
      cre_q  <= act_d && f_psr && f_cfg;
      ub_q   <= !(act_d && f_psr && f_be[1]);
      lb_q   <= !(act_d && f_psr && f_be[0]);
    end
  end

  assign req_ready  = ready_q;
  assign dpd_active = dpd;
  assign bus_clk    = 1'b0;
  assign bus_adv_n  = adv_q;
  assign bus_oe_n   = oe_q;
  assign bus_we_n   = we_q;
  assign flash_ce_n = fce_q;
  assign psram_ce_n = pce_q;
  assign psram_cre  = cre_q;
  assign psram_ub_n = ub_q;
  assign psram_lb_n = lb_q;
  assign bus_a_hi   = ahi_q;
  assign adq_out    = dout_q;
  assign adq_oe     = drv_q;

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    flash_ce_n || psram_ce_n); // R2

  AST_LATCH_STROBES: assert property (@(posedge clk) disable iff (rst)
    !bus_adv_n |-> (bus_oe_n && bus_we_n && adq_oe && (flash_ce_n != psram_ce_n))); // R3

  AST_READ_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> !adq_oe); // R4

  AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !bus_we_n |-> (adq_oe && bus_oe_n)); // R5

  AST_FLASH_NO_PSRAM_LINES: assert property (@(posedge clk) disable iff (rst)
    !flash_ce_n |-> (psram_ub_n && psram_lb_n && !psram_cre)); // R6

  AST_FLASH_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    !flash_ce_n |-> $past(psram_ce_n)); // R8

  AST_PSRAM_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    !psram_ce_n |-> $past(flash_ce_n)); // R8

  AST_WAKE_ONLY_SELECT: assert property (@(posedge clk) disable iff (rst)
    (dpd_active && !psram_ce_n) |-> (bus_adv_n && bus_oe_n && bus_we_n)); // R11

  AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (flash_ce_n && psram_ce_n)); // R13

endmodule

// File: tb/muxbus_dual_ctrl_tb.sv
module muxbus_dual_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int A_CYC      = 2;
  localparam int D_CYC      = 3;
  localparam int T_CYC      = 2;
  localparam int W_CYC      = 6;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic        req_psram = 1'b0;
  logic        req_cfg = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b00;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        dpd_active;
  logic        bus_clk, bus_adv_n, bus_oe_n, bus_we_n;
  logic        flash_ce_n, psram_ce_n, psram_cre, psram_ub_n, psram_lb_n;
  logic [7:0]  bus_a_hi;
  logic [15:0] adq_out;
  logic        adq_oe;
  logic [15:0] adq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_dual_ctrl #(
    .ADDR_CYC (A_CYC),
    .DATA_CYC (D_CYC),
    .TURN_CYC (T_CYC),
    .WAKE_CYC (W_CYC)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_psram(req_psram), .req_cfg(req_cfg),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .dpd_active(dpd_active),
    .bus_clk(bus_clk), .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .flash_ce_n(flash_ce_n), .psram_ce_n(psram_ce_n),
    .psram_cre(psram_cre), .psram_ub_n(psram_ub_n), .psram_lb_n(psram_lb_n),
    .bus_a_hi(bus_a_hi), .adq_out(adq_out), .adq_oe(adq_oe), .adq_in(adq_in)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- memory model on the bus ----------------
  logic [15:0] m_flash [16];
  logic [15:0] m_psram [16];
  logic [15:0] m_rcr = 16'h0010;
  logic [15:0] m_bcr = 16'h0000;
  logic        m_dpd = 1'b0;
  logic        m_pce_prev = 1'b1;
  logic [23:0] m_lat = '0;

  always_comb begin
    if (!flash_ce_n && !bus_oe_n)      adq_in = m_flash[m_lat[3:0]];
    else if (!psram_ce_n && !bus_oe_n) adq_in = psram_cre ? (m_lat[19] ? m_bcr : m_rcr) : m_psram[m_lat[3:0]];
    else                               adq_in = 16'hBEEF;
  end

  always @(posedge clk) begin
    m_pce_prev <= psram_ce_n;
    if (!bus_adv_n && (!flash_ce_n || !psram_ce_n)) m_lat <= {bus_a_hi, adq_out};
    if (!bus_we_n && !flash_ce_n) m_flash[m_lat[3:0]] <= adq_out;
    if (!bus_we_n && !psram_ce_n && !m_dpd) begin
      if (psram_cre) begin
        if (m_lat[19]) m_bcr <= adq_out;
        else           m_rcr <= adq_out;
      end else begin
        m_psram[m_lat[3:0]] <= {psram_ub_n ? m_psram[m_lat[3:0]][15:8] : adq_out[15:8],
                                psram_lb_n ? m_psram[m_lat[3:0]][7:0]  : adq_out[7:0]};
      end
    end
    if (psram_ce_n && !m_pce_prev) begin
      if (m_dpd) begin
        m_dpd <= 1'b0;
        m_rcr <= 16'h0010;
      end else if (!m_rcr[4]) begin
        m_dpd <= 1'b1;
      end
    end
  end

  // ---------------- reference state and expectations ----------------
  logic [15:0] r_flash [16];
  logic [15:0] r_psram [16];
  logic [15:0] r_rcr = 16'h0010;
  logic [15:0] r_bcr = 16'h0000;
  logic        r_dpd = 1'b0;

  logic [15:0] exp_q[$];
  logic [23:0] e_addr = '0;
  logic [15:0] e_wd = '0;
  logic [1:0]  e_be = '0;
  logic        e_cre = 1'b0;
  logic        e_wake = 1'b0;

  task automatic access(input logic [1:0] op, input logic psr, input logic cfg,
                        input logic [23:0] addr, input logic [15:0] wd, input logic [1:0] be);
    logic blk, noop;
    logic [15:0] ev;
    while (!req_ready) @(negedge clk);
    blk  = psr && r_dpd && (op != 2'd2);
    noop = (op == 2'd2) && !r_dpd;
    e_addr = addr; e_wd = wd; e_be = be;
    e_cre  = psr && cfg && (op != 2'd2);
    e_wake = (op == 2'd2);
    if (op == 2'd2) begin
      if (r_dpd) begin
        r_dpd = 1'b0;
        r_rcr = 16'h0010;
      end
    end else if (blk) begin
      if (op != 2'd1) exp_q.push_back(16'h0000);
    end else if (op == 2'd1) begin
      if (!psr) r_flash[addr[3:0]] = wd;
      else if (cfg) begin
        if (addr[19]) r_bcr = wd; else r_rcr = wd;
      end else begin
        if (be[1]) r_psram[addr[3:0]][15:8] = wd[15:8];
        if (be[0]) r_psram[addr[3:0]][7:0]  = wd[7:0];
      end
    end else begin
      if (!psr)     ev = r_flash[addr[3:0]];
      else if (cfg) ev = addr[19] ? r_bcr : r_rcr;
      else          ev = r_psram[addr[3:0]];
      exp_q.push_back(ev);
    end
    if (psr && !blk && (op != 2'd2) && !r_rcr[4]) r_dpd = 1'b1;
    req_op = op; req_psram = psr; req_cfg = cfg; req_addr = addr; req_wdata = wd; req_be = be;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (blk || noop) chk(req_ready == 1'b1, "R10 ready stays high on absorbed request", req_ready, 1);
    else             chk(req_ready == 1'b0, "R13 ready low after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
  endtask

  // ---------------- scoreboard monitor ----------------
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected read data", rd_data, 0);
      else begin
        logic [15:0] ev;
        ev = exp_q.pop_front();
        chk(rd_data == ev, "R4 read data", rd_data, ev);
      end
    end
  end

  // ---------------- protocol monitor ----------------
  int adv_run = 0, oe_run = 0, we_run = 0, pce_run = 0, gap = 0;
  int both_low = 0, clk_high = 0, pce_falls = 0;
  logic pce_wake = 1'b0;
  logic have_last = 1'b0, last_die = 1'b0;
  logic prev_f = 1'b1, prev_p = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!flash_ce_n && !psram_ce_n) both_low++;
      if (bus_clk) clk_high++;
      if (!bus_adv_n) begin
        adv_run++;
        chk({bus_a_hi, adq_out} == e_addr && adq_oe, "R3 address on bus", {bus_a_hi, adq_out}, e_addr);
      end else if (adv_run != 0) begin
        chk(adv_run == A_CYC, "R3 address phase length", adv_run, A_CYC);
        adv_run = 0;
      end
      if (!bus_oe_n) begin
        oe_run++;
        chk(!adq_oe && bus_we_n && bus_adv_n, "R4 bus released in read", adq_oe, 0);
      end else if (oe_run != 0) begin
        chk(oe_run == D_CYC, "R4 read phase length", oe_run, D_CYC);
        oe_run = 0;
      end
      if (!bus_we_n) begin
        we_run++;
        chk(adq_oe && adq_out == e_wd && bus_oe_n, "R5 write data on bus", adq_out, e_wd);
      end else if (we_run != 0) begin
        chk(we_run == D_CYC, "R5 write phase length", we_run, D_CYC);
        we_run = 0;
      end
      if (!flash_ce_n)
        chk(psram_ub_n && psram_lb_n && !psram_cre, "R6 R7 flash leaves PSRAM lines idle",
            {psram_ub_n, psram_lb_n, psram_cre}, 3'b110);
      if (!psram_ce_n && !e_wake) begin
        chk(psram_ub_n == !e_be[1] && psram_lb_n == !e_be[0], "R6 byte enables",
            {psram_ub_n, psram_lb_n}, {!e_be[1], !e_be[0]});
        chk(psram_cre == e_cre, "R7 cre level", psram_cre, e_cre);
      end
      // select falls and the idle gap before them
      if ((!flash_ce_n && prev_f) || (!psram_ce_n && prev_p)) begin
        if (have_last) begin
          if (last_die != !psram_ce_n) chk(gap >= 1 + T_CYC, "R8 die switch gap", gap, 1 + T_CYC);
          else                         chk(gap >= 1, "R8 same die gap", gap, 1);
        end
        have_last = 1'b1;
        last_die  = !psram_ce_n;
        gap = 0;
      end
      if (flash_ce_n && psram_ce_n) gap++;
      if (!psram_ce_n && prev_p) begin
        pce_falls++;
        pce_wake = e_wake;
      end
      if (!psram_ce_n) pce_run++;
      else if (pce_run != 0) begin
        if (pce_wake) chk(pce_run == W_CYC, "R11 wake hold length", pce_run, W_CYC);
        pce_run = 0;
      end
      prev_f = flash_ce_n;
      prev_p = psram_ce_n;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL R13 watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int falls_before;
    for (int i = 0; i < 16; i++) begin
      m_flash[i] = 16'h1000 + 16'(i * 16'h0111);
      r_flash[i] = 16'h1000 + 16'(i * 16'h0111);
      m_psram[i] = 16'h2000 + 16'(i * 16'h0203);
      r_psram[i] = 16'h2000 + 16'(i * 16'h0203);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(flash_ce_n && psram_ce_n && bus_adv_n && bus_oe_n && bus_we_n && psram_ub_n && psram_lb_n,
        "R1 strobes high in reset", {flash_ce_n, psram_ce_n, bus_adv_n, bus_oe_n, bus_we_n}, 5'h1f);
    chk(!psram_cre && !adq_oe && !dpd_active && req_ready, "R1 idle flags in reset",
        {psram_cre, adq_oe, dpd_active, req_ready}, 4'b0001);
    chk(bus_clk == 1'b0, "R12 bus clock low in reset", bus_clk, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && flash_ce_n && psram_ce_n, "R1 idle after reset", req_ready, 1);

    // flash write then read (R3 R4 R5)
    access(2'd1, 1'b0, 1'b0, 24'h120003, 16'hA5A5, 2'b11);
    access(2'd0, 1'b0, 1'b0, 24'h120003, 16'h0000, 2'b11);
    // PSRAM full write, read, then partial byte writes (R6)
    access(2'd1, 1'b1, 1'b0, 24'h050005, 16'h1234, 2'b11);
    access(2'd0, 1'b1, 1'b0, 24'h050005, 16'h0000, 2'b11);
    access(2'd1, 1'b1, 1'b0, 24'h050005, 16'hFFEE, 2'b01);
    access(2'd0, 1'b1, 1'b0, 24'h050005, 16'h0000, 2'b11);
    access(2'd1, 1'b1, 1'b0, 24'h050005, 16'h7700, 2'b10);
    access(2'd0, 1'b1, 1'b0, 24'h050005, 16'h0000, 2'b11);
    // register accesses (R7), flash ignores cfg
    access(2'd1, 1'b1, 1'b1, 24'h080000, 16'h8A5F, 2'b11);
    access(2'd0, 1'b1, 1'b1, 24'h080000, 16'h0000, 2'b11);
    access(2'd0, 1'b1, 1'b1, 24'h000000, 16'h0000, 2'b11);
    access(2'd0, 1'b0, 1'b1, 24'h000007, 16'h0000, 2'b11);
    access(2'd3, 1'b0, 1'b0, 24'h000003, 16'h0000, 2'b00);
    // refresh write keeping bit 4 set: no power-down (R9)
    access(2'd1, 1'b1, 1'b1, 24'h000000, 16'h0011, 2'b11);
    @(negedge clk);
    chk(dpd_active == 1'b0, "R9 bit4 set keeps power on", dpd_active, 0);
    access(2'd0, 1'b1, 1'b1, 24'h000000, 16'h0000, 2'b11);
    // bus register write with bit 4 clear does not power down (R9)
    access(2'd1, 1'b1, 1'b1, 24'h080000, 16'h0000, 2'b11);
    chk(dpd_active == 1'b0, "R9 bus register write ignored", dpd_active, 0);
    // wake while powered on does nothing (R11)
    falls_before = pce_falls;
    access(2'd2, 1'b1, 1'b0, 24'h000000, 16'h0000, 2'b00);
    repeat (2) @(negedge clk);
    chk(pce_falls == falls_before, "R11 wake while awake is silent", pce_falls, falls_before);
    // enter power-down (R9)
    access(2'd1, 1'b1, 1'b1, 24'h000000, 16'h0000, 2'b11);
    chk(dpd_active == 1'b1, "R9 power-down entered", dpd_active, 1);
    // absorbed PSRAM requests, flash still works (R10)
    falls_before = pce_falls;
    access(2'd0, 1'b1, 1'b0, 24'h050005, 16'h0000, 2'b11);
    access(2'd1, 1'b1, 1'b0, 24'h050005, 16'hDEAD, 2'b11);
    access(2'd0, 1'b0, 1'b0, 24'h000004, 16'h0000, 2'b11);
    repeat (2) @(negedge clk);
    chk(pce_falls == falls_before, "R10 no PSRAM select in power-down", pce_falls, falls_before);
    chk(dpd_active == 1'b1, "R10 still powered down", dpd_active, 1);
    // wake (R11)
    access(2'd2, 1'b1, 1'b0, 24'h000000, 16'h0000, 2'b00);
    chk(dpd_active == 1'b0, "R11 wake clears power-down", dpd_active, 0);
    access(2'd0, 1'b1, 1'b1, 24'h000000, 16'h0000, 2'b11);
    access(2'd0, 1'b1, 1'b0, 24'h050005, 16'h0000, 2'b11);
    // shadow back at default: a normal PSRAM write keeps power on (R9 R11)
    access(2'd1, 1'b1, 1'b0, 24'h000009, 16'h4321, 2'b11);
    chk(dpd_active == 1'b0, "R11 shadow default after wake", dpd_active, 0);
    // interleaved traffic for switch gaps (R8)
    for (int k = 0; k < 8; k++) begin
      access(2'd1, k[0], 1'b0, 24'(k + 2), 16'(16'h3300 + k), 2'b11);
      access(2'd0, !k[0], 1'b0, 24'(k + 1), 16'h0000, 2'b11);
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 every read answered", exp_q.size(), 0);
    chk(both_low == 0, "R2 selects never both low", both_low, 0);
    chk(clk_high == 0, "R12 bus clock held low", clk_high, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule